// File: doc/BRIEF.md
# DDR3 Command Decoder and Bank Tracker

This block watches the command pins of a two-rank DDR3 memory channel and works out, on every rising clock edge, which command was issued and to which rank and bank. For each of the sixteen banks (two ranks of eight) it keeps whether the bank is open and which row was opened. It reports the decoded command one cycle later, along with three qualifiers:
- autoprecharge, taken from address bit 10 on a read or write;
- precharge-all, taken from address bit 10 on a precharge;
- burst chop, taken from address bit 12 on a read or write.

It is meant to sit beside a memory controller or a memory model. A monitor, a protocol checker or a scoreboard can follow the bank state and catch commands that break the open/closed rules. A command that breaks those rules raises a one-cycle error pulse and leaves the bank state alone. The row stored for any bank can be read at any time through a combinational query port.

Top module: `ddr3_cmd_tracker`

## Requirements
- R1: A command is taken for rank r only when cs_n[r] is low and every other select is high. With all selects high, nothing is reported and bank state holds.
- R2: When more than one select is low at a sampled edge, err pulses and bank state holds.
- R3: When cke is low at a sampled edge, no command is decoded: cmd_valid and err stay low and bank state holds.
- R4: The pins {ras_n,cas_n,we_n} decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 111 no-op. An accepted command shows cmd_valid and cmd_code one cycle after its edge, with cmd_rank and cmd_bank. The cmd_code values are 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode set. A no-op reports nothing.
- R5: An accepted activate opens the bank (bank_open bit rank*8+bank) and stores addr as its row. qry_row returns the stored row for qry_rank/qry_bank, and reads 0 after reset.
- R6: A read or write to a closed bank, or an activate to an open bank, gives err for one cycle with cmd_valid low and no state change.
- R7: A read or write with addr[10] high sets auto_pre and closes the addressed bank. With addr[10] low the bank stays open.
- R8: A precharge with addr[10] high closes every bank of the rank and sets pre_all. With addr[10] low it closes only the bank named by ba. Precharging a closed bank is legal.
- R9: burst_chop is high for an accepted read or write with addr[12] low, and low for every other output cycle.
- R10: A refresh is accepted only when every bank of its rank is closed. Otherwise err pulses.
- R11: The pattern 110 on {ras_n,cas_n,we_n} is unsupported and gives err.
- R12: During reset all banks are closed and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low suppresses decode |
| cs_n | input | NRANK | Active-low rank selects |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ROW_W | Row/column address, bit 10 AP, bit 12 BC |
| qry_rank | input | RANK_W | Rank for the row query |
| qry_bank | input | BA_W | Bank for the row query |
| cmd_valid | output | 1 | Accepted command pulse |
| cmd_code | output | 3 | Decoded command code |
| cmd_rank | output | RANK_W | Rank of the command |
| cmd_bank | output | BA_W | Bank of the command |
| auto_pre | output | 1 | Read/write with autoprecharge |
| pre_all | output | 1 | Precharge of all banks |
| burst_chop | output | 1 | Read/write with chopped burst |
| err | output | 1 | Illegal command pulse |
| bank_open | output | NRANK*NBANK | Open flag per bank |
| qry_row | output | ROW_W | Stored row of the queried bank |

## Verification
The hardest case to reach is a legal refresh on a rank that has been busy. Every bank of that rank must be closed at once, while the other rank keeps banks open so that rank separation is also tested. The bench reaches this with directed runs. It opens several banks in both ranks, closes one rank with a precharge-all, and then refreshes it. It repeats this with single-bank precharges and with reads and writes that autoprecharge. A long weighted random phase follows, mixing deselects, double selects and cke-low cycles, so that rejected commands also land on every bank state.

// File: rtl/ddr3_cmd_tracker.sv
module ddr3_cmd_tracker #(
  parameter int NRANK  = 2,
  parameter int NBANK  = 8,
  parameter int BA_W   = 3,
  parameter int ROW_W  = 16,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  parameter int RANK_W = (NRANK > 1) ? $clog2(NRANK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic [NRANK-1:0]        cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic [ROW_W-1:0]        addr,
  input  logic [RANK_W-1:0]       qry_rank,
  input  logic [BA_W-1:0]         qry_bank,
  output logic                    cmd_valid,
  output logic [2:0]              cmd_code,
  output logic [RANK_W-1:0]       cmd_rank,
  output logic [BA_W-1:0]         cmd_bank,
  output logic                    auto_pre,
  output logic                    pre_all,
  output logic                    burst_chop,
  output logic                    err,
  output logic [NRANK*NBANK-1:0]  bank_open,
  output logic [ROW_W-1:0]        qry_row
);
  localparam int NB = NRANK * NBANK;
  localparam int IDX_W = $clog2(NB);
  localparam logic [2:0] OP_NOP = 3'd0, OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
                         OP_PRE = 3'd4, OP_REF = 3'd5, OP_MRS = 3'd6, OP_BAD = 3'd7;

  logic [ROW_W-1:0] row_q [NB];
  logic [2:0]        op;
  logic [RANK_W-1:0] rk;
  logic [IDX_W-1:0]  idx;
  int                nsel;
  logic              take, multi, bad, ok, rw, rank_busy;
  logic [NB-1:0]     open_nx, rank_mask;

  always_comb begin
    case ({ras_n, cas_n, we_n})
      3'b011:  op = OP_ACT;
      3'b101:  op = OP_RD;
      3'b100:  op = OP_WR;
      3'b010:  op = OP_PRE;
      3'b001:  op = OP_REF;
      3'b000:  op = OP_MRS;
      3'b111:  op = OP_NOP;
      default: op = OP_BAD;
    endcase
  end

  always_comb begin
    nsel = 0;
    rk = '0;
    for (int r = 0; r < NRANK; r++)
      if (!cs_n[r]) begin
        nsel = nsel + 1;
        rk = RANK_W'(r);
      end
  end

  always_comb begin
    rank_mask = '0;
    for (int b = 0; b < NBANK; b++)
      rank_mask[int'(rk) * NBANK + b] = 1'b1;
  end

  assign idx       = IDX_W'(int'(rk) * NBANK + int'(ba));
  assign rank_busy = |(bank_open & rank_mask);
  assign rw        = (op == OP_RD) || (op == OP_WR);
  assign multi     = cke && (nsel > 1);
  assign take      = cke && (nsel == 1) && (op != OP_NOP);
  assign bad       = multi || (take && ((op == OP_BAD) ||
                     ((op == OP_ACT) && bank_open[idx]) ||
                     (rw && !bank_open[idx]) ||
                     ((op == OP_REF) && rank_busy)));
  assign ok        = take && !bad;

  always_comb begin
    open_nx = bank_open;
    if (ok) begin
      if (op == OP_ACT) open_nx[idx] = 1'b1;
      else if (rw && addr[AP_BIT]) open_nx[idx] = 1'b0;
      else if (op == OP_PRE) begin
        if (addr[AP_BIT]) open_nx = bank_open & ~rank_mask;
        else open_nx[idx] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open  <= '0;
      cmd_valid  <= 1'b0;
      cmd_code   <= OP_NOP;
      cmd_rank   <= '0;
      cmd_bank   <= '0;
      auto_pre   <= 1'b0;
      pre_all    <= 1'b0;
      burst_chop <= 1'b0;
      err        <= 1'b0;
    end else begin
      bank_open  <= open_nx;
      cmd_valid  <= ok;
      cmd_code   <= ok ? op : OP_NOP;
      cmd_rank   <= ok ? rk : '0;
      cmd_bank   <= ok ? ba : '0;
      auto_pre   <= ok && rw && addr[AP_BIT];
      pre_all    <= ok && (op == OP_PRE) && addr[AP_BIT];
      burst_chop <= ok && rw && !addr[BC_BIT];
      err        <= bad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) row_q[i] <= '0;
    end else if (ok && op == OP_ACT) begin
      row_q[idx] <= addr;
    end
  end

  assign qry_row = row_q[int'(qry_rank) * NBANK + int'(qry_bank)];

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && cmd_valid)); // R6
  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |=> (!cmd_valid && !err && $stable(bank_open))); // R1
  AST_CKE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (!cmd_valid && !err && $stable(bank_open))); // R3
  AST_ERR_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (bank_open == $past(bank_open))); // R6
  AST_QUAL_ONLY_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_pre || burst_chop) |-> (cmd_valid && (cmd_code == OP_RD || cmd_code == OP_WR))); // R9
  AST_PREALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |-> (cmd_code == OP_PRE && $countones(bank_open) <= NB - NBANK)); // R8
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_ACT) |-> bank_open[int'(cmd_rank) * NBANK + int'(cmd_bank)]); // R5
endmodule

// File: tb/ddr3_cmd_tracker_test.sv
module ddr3_cmd_tracker_test;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, cke = 1;
  logic [1:0] cs_n = 2'b11;
  logic ras_n = 1, cas_n = 1, we_n = 1;
  logic [2:0] ba = 0, qry_bank = 0;
  logic [15:0] addr = 0;
  logic qry_rank = 0;
  logic cmd_valid, auto_pre, pre_all, burst_chop, err, cmd_rank;
  logic [2:0] cmd_code, cmd_bank;
  logic [15:0] bank_open, qry_row;

  ddr3_cmd_tracker uut (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .qry_rank(qry_rank), .qry_bank(qry_bank),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
    .auto_pre(auto_pre), .pre_all(pre_all), .burst_chop(burst_chop), .err(err),
    .bank_open(bank_open), .qry_row(qry_row));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit m_open [2][8];
  int m_row [2][8];
  int e_valid, e_code, e_rank, e_bank, e_ap, e_pa, e_bc, e_err;

  function automatic int open_vec();
    int v = 0;
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 8; b++)
        if (m_open[r][b]) v = v | (1 << (r*8 + b));
    return v;
  endfunction

  always @(posedge clk) begin
    e_valid = 0; e_code = 0; e_rank = 0; e_bank = 0; e_ap = 0; e_pa = 0; e_bc = 0; e_err = 0;
    if (!rst_n) begin
      for (int r = 0; r < 2; r++)
        for (int b = 0; b < 8; b++) begin m_open[r][b] = 0; m_row[r][b] = 0; end
    end else if (cke) begin
      int ns, r, code, ok;
      ns = (cs_n[0] ? 0 : 1) + (cs_n[1] ? 0 : 1);
      r = cs_n[0] ? 1 : 0;
      code = -1;
      if ({ras_n,cas_n,we_n} == 3'b011) code = 1;
      if ({ras_n,cas_n,we_n} == 3'b101) code = 2;
      if ({ras_n,cas_n,we_n} == 3'b100) code = 3;
      if ({ras_n,cas_n,we_n} == 3'b010) code = 4;
      if ({ras_n,cas_n,we_n} == 3'b001) code = 5;
      if ({ras_n,cas_n,we_n} == 3'b000) code = 6;
      if ({ras_n,cas_n,we_n} == 3'b111) code = 0;
      if (ns > 1) e_err = 1;
      else if (ns == 1 && code != 0) begin
        ok = 1;
        if (code == -1) ok = 0;
        if (code == 1 && m_open[r][ba]) ok = 0;
        if ((code == 2 || code == 3) && !m_open[r][ba]) ok = 0;
        if (code == 5)
          for (int b = 0; b < 8; b++) if (m_open[r][b]) ok = 0;
        if (!ok) e_err = 1;
        else begin
          e_valid = 1; e_code = code; e_rank = r; e_bank = ba;
          if (code == 1) begin m_open[r][ba] = 1; m_row[r][ba] = addr; end
          if (code == 2 || code == 3) begin
            e_bc = !addr[12];
            if (addr[10]) begin e_ap = 1; m_open[r][ba] = 0; end
          end
          if (code == 4) begin
            if (addr[10]) begin
              e_pa = 1;
              for (int b = 0; b < 8; b++) m_open[r][b] = 0;
            end else m_open[r][ba] = 0;
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  bit started = 0;
  always @(negedge clk) if (started) begin
    chk("R4 cmd_valid", cmd_valid, e_valid);
    chk("R4 cmd_code", cmd_code, e_code);
    chk("R1 cmd_rank", cmd_rank, e_rank);
    chk("R4 cmd_bank", cmd_bank, e_bank);
    chk("R7 auto_pre", auto_pre, e_ap);
    chk("R8 pre_all", pre_all, e_pa);
    chk("R9 burst_chop", burst_chop, e_bc);
    chk("R6 err", err, e_err);
    chk("R5 bank_open", bank_open, open_vec());
    chk("R5 qry_row", qry_row, m_row[qry_rank][qry_bank]);
  end

  task automatic issue(input bit c, input bit [1:0] cs, input bit [2:0] pins,
                       input bit [2:0] b, input bit [15:0] a);
    @(posedge clk); #(PERIOD/4);
    cke = c; cs_n = cs; {ras_n, cas_n, we_n} = pins; ba = b; addr = a;
    qry_rank = $urandom_range(0, 1); qry_bank = $urandom_range(0, 7);
  endtask

  localparam bit [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                       REF = 3'b001, MRS = 3'b000, NOP = 3'b111, BAD = 3'b110;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/4); started = 1;
    @(posedge clk); #(PERIOD/4);
    chk("R12 reset bank_open", bank_open, 0);
    chk("R12 reset err", err, 0);
    rst_n = 1;
    // R10 refresh on idle rank, R4 mode set
    issue(1, 2'b10, REF, 0, 0);
    issue(1, 2'b01, MRS, 0, 16'h0123);
    // R5 open banks on both ranks
    for (int b = 0; b < 8; b += 2) issue(1, 2'b10, ACT, b[2:0], 16'h1000 + b[15:0]);
    for (int b = 1; b < 8; b += 3) issue(1, 2'b01, ACT, b[2:0], 16'h2000 + b[15:0]);
    // R6 illegal activates, reads, writes
    issue(1, 2'b10, ACT, 0, 16'hdead);
    issue(1, 2'b10, RD, 1, 0);
    issue(1, 2'b01, WR, 0, 0);
    // R9 chopped and full bursts, R7 no autoprecharge
    issue(1, 2'b10, RD, 2, 16'h0000);
    issue(1, 2'b10, WR, 2, 16'h1000);
    // R10 refresh rejected on busy rank
    issue(1, 2'b10, REF, 0, 0);
    // R2 both selects, R1 deselect, R3 cke low, R11 unsupported
    issue(1, 2'b00, PRE, 0, 16'h0400);
    issue(1, 2'b11, PRE, 0, 16'h0400);
    issue(0, 2'b10, PRE, 0, 16'h0400);
    issue(1, 2'b10, BAD, 0, 0);
    // R7 autoprecharge closes bank
    issue(1, 2'b10, WR, 4, 16'h0400);
    issue(1, 2'b10, RD, 4, 0);
    // R8 single precharge, then all-bank precharge, then refresh
    issue(1, 2'b10, PRE, 6, 0);
    issue(1, 2'b10, PRE, 3, 0);
    issue(1, 2'b10, PRE, 5, 16'h0400);
    issue(1, 2'b10, REF, 0, 0);
    issue(1, 2'b01, REF, 0, 0);
    issue(1, 2'b01, PRE, 1, 0);
    issue(1, 2'b01, RD, 4, 16'h0400);
    issue(1, 2'b01, WR, 7, 16'h0400);
    issue(1, 2'b01, REF, 0, 0);
    issue(1, 2'b11, NOP, 0, 0);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int w;
      bit [1:0] cs;
      bit [2:0] p;
      bit c;
      w = $urandom_range(0, 99);
      cs = (w < 42) ? 2'b10 : (w < 84) ? 2'b01 : (w < 93) ? 2'b11 : 2'b00;
      c = ($urandom_range(0, 19) != 0);
      w = $urandom_range(0, 99);
      p = (w < 25) ? ACT : (w < 45) ? RD : (w < 60) ? WR : (w < 78) ? PRE :
          (w < 86) ? REF : (w < 90) ? MRS : (w < 97) ? NOP : BAD;
      issue(c, cs, p, 3'($urandom_range(0, 7)), 16'($urandom));
    end
    issue(1, 2'b11, NOP, 0, 0);
    @(posedge clk); @(negedge clk);
    report();
  end
endmodule